// File: doc/BRIEF.md
# Transmit Cell-Bus Polling Master

This block is the transmit master of a parallel cell bus that serves several line-side PHY ports. The bus carries fixed-length cells. Each clock it puts the next port's address on a shared address bus. It records whether that port has room for a whole cell, and picks an eligible port in round-robin order. It then pulls the cell word by word from that port's upstream source and drives it onto the PHY data bus. Each word goes out with an active-low enable, a start-of-cell flag on the first word and an odd parity bit.

Two status schemes are available, chosen by parameter. In polled status, one cell-available input answers for the address put out one cycle earlier. In direct status, each port has its own cell-available line. Direct status is meant for configurations of four ports or fewer. Port addresses are either the port number itself or a parameter table of chosen 5-bit addresses. Cells may follow each other with no idle cycle between them. Each upstream source holds a "whole cell ready" flag and presents the current word on its data lane. It moves to its next word on every read strobe.

Top module: `cellbus_tx_master`

## Requirements
- R1: While reset is asserted, the enable output is high and start-of-cell is low. No read strobe is active, and the address bus shows the address of port 0.
- R2: The address bus moves to the next port every clock, from port 0 to port NPORTS-1 and then back to 0. The address of port k is k when the map is off. When the map is on, it is the 5-bit field at bits 5k+4..5k of the map parameter.
- R3: In polled status, a port's availability is the cell-available input sampled at the end of the cycle after its address was on the bus. That value holds until the port is polled again.
- R4: In direct status, the availability of port k is cell-available line k, sampled on every clock.
- R5: A port is eligible when its availability is set and its source ready flag is high. The selection is the first eligible port at or after the round-robin pointer, wrapping at NPORTS. After a selection the pointer moves to the port after the chosen one.
- R6: A cell from the selected port appears on the next WORDS consecutive cycles with enable low. Start-of-cell is high on the first of those cycles only. The port's read strobe is high in the cycle before each word appears, and at most one strobe is high at a time.
- R7: If a port is eligible in the cycle of the current cell's last word, the next cell's first word follows with no idle cycle.
- R8: Whenever enable is low, the data bus together with the parity bit holds an odd number of ones.
- R9: WORDS is the cell length in octets divided by the bus width in octets. Supported lengths are 52 at any width, 53 at 8 bits, 54 at 16 bits and 56 at 32 bits.
- R10: Selecting a port clears its availability. This takes precedence over a status sample in the same cycle, so the port must report room again before it is served again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the PHY side and the sources |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| phy_addr | output | 5 | Address of the port being polled |
| phy_enb_n | output | 1 | Low while a cell word is on the data bus |
| phy_clav | input | DIRECT ? NPORTS : 1 | Cell-available response(s) |
| phy_data | output | DW | Cell word |
| phy_soc | output | 1 | High on the first word of a cell |
| phy_par | output | 1 | Odd parity over phy_data |
| src_ready | input | NPORTS | Per-port flag: a cell not yet started is waiting |
| src_data | input | NPORTS*DW | Per-port current word, port k at bits DW*k upward |
| src_rd | output | NPORTS | Per-port read strobe; the source advances one word per strobe |

## Verification
The checks assume that each source keeps its ready flag high only while an unstarted whole cell waits. The flag must drop once the first word of that cell has been taken. The checks also assume that a source presents the next word after every strobe. The bench sources count cells and words per port and update the flag from those counts, so this holds by construction. The PHY model answers polled status for the address of the previous cycle, and in direct status it drives one line per port. Willingness changes in phases (all ports, only even ports, then a shifting pattern) so that ports are skipped, resumed and served back to back.

// File: rtl/cbtx_pkg.sv
package cbtx_pkg;
  localparam int ADDR_W    = 5;
  localparam int MAX_PORTS = 31;
  typedef logic [ADDR_W-1:0] phy_addr_t;
endpackage

// File: rtl/cbtx_scanner.sv
module cbtx_scanner
  import cbtx_pkg::*;
#(
  parameter int NPORTS  = 4,
  parameter bit DIRECT  = 1'b0,
  parameter bit USE_MAP = 1'b0,
  parameter logic [MAX_PORTS*ADDR_W-1:0] ADDR_MAP = '0
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [(DIRECT ? NPORTS : 1)-1:0] clav,
  input  logic                             clr_valid,
  input  logic [$clog2(NPORTS)-1:0]        clr_idx,
  output phy_addr_t                        phy_addr,
  output logic [NPORTS-1:0]                stat
);
  localparam int IDXW = $clog2(NPORTS);
  localparam logic [IDXW-1:0] LAST = IDXW'(NPORTS - 1);

  logic [IDXW-1:0]   scan_q, scan_d, prev_q;
  logic              prev_v_q;
  logic [NPORTS-1:0] stat_q, stat_d;

  function automatic phy_addr_t map_addr(logic [IDXW-1:0] i);
    if (USE_MAP) return ADDR_MAP[ADDR_W*i +: ADDR_W];
    else         return phy_addr_t'(i);
  endfunction

  always_comb scan_d = (scan_q == LAST) ? '0 : scan_q + 1'b1;

  generate
    if (DIRECT) begin : g_direct
      always_comb begin
        stat_d = clav;
        if (clr_valid) stat_d[clr_idx] = 1'b0;
      end
    end else begin : g_poll
      always_comb begin
        stat_d = stat_q;
        if (prev_v_q)  stat_d[prev_q]  = clav[0];
        if (clr_valid) stat_d[clr_idx] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_q   <= '0;
      prev_q   <= '0;
      prev_v_q <= 1'b0;
      stat_q   <= '0;
    end else begin
      scan_q   <= scan_d;
      prev_q   <= scan_q;
      prev_v_q <= 1'b1;
      stat_q   <= stat_d;
    end
  end

  assign phy_addr = map_addr(scan_q);
  assign stat     = stat_q;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |=> !stat_q[$past(clr_idx)]); // R10
endmodule

// File: rtl/cbtx_rr_arb.sv
module cbtx_rr_arb #(
  parameter int NPORTS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPORTS-1:0]         elig,
  input  logic                      take,
  output logic                      any,
  output logic [$clog2(NPORTS)-1:0] pick
);
  localparam int IDXW = $clog2(NPORTS);
  localparam logic [IDXW-1:0] LAST = IDXW'(NPORTS - 1);

  logic [IDXW-1:0] ptr_q, ptr_d;

  function automatic logic [IDXW-1:0] wrap_idx(logic [IDXW-1:0] base, int off);
    int s;
    s = int'(base) + off;
    if (s >= NPORTS) s = s - NPORTS;
    return IDXW'(s);
  endfunction

  // descending scan: the smallest offset from the pointer wins
  always_comb begin
    any  = 1'b0;
    pick = ptr_q;
    for (int off = NPORTS - 1; off >= 0; off--) begin
      if (elig[wrap_idx(ptr_q, off)]) begin
        any  = 1'b1;
        pick = wrap_idx(ptr_q, off);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (take) ptr_d = (pick == LAST) ? '0 : pick + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  AST_TAKE_HAS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> any); // R5
endmodule

// File: rtl/cbtx_sender.sv
module cbtx_sender #(
  parameter int NPORTS = 4,
  parameter int DW     = 32,
  parameter int WORDS  = 13
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      any,
  input  logic [$clog2(NPORTS)-1:0] pick,
  input  logic [NPORTS*DW-1:0]      src_data,
  output logic                      take,
  output logic [NPORTS-1:0]         src_rd,
  output logic                      phy_enb_n,
  output logic                      phy_soc,
  output logic [DW-1:0]             phy_data,
  output logic                      phy_par
);
  localparam int IDXW = $clog2(NPORTS);
  localparam int CW   = $clog2(WORDS);
  localparam logic [CW-1:0] WLAST = CW'(WORDS - 1);

  logic            busy_q, busy_d;
  logic [IDXW-1:0] cur_q, cur_d;
  logic [CW-1:0]   wcnt_q, wcnt_d;
  logic            last;
  logic [DW-1:0]   word;

  assign last = busy_q && (wcnt_q == WLAST);
  assign take = (!busy_q || last) && any;
  assign word = src_data[DW*cur_q +: DW];

  always_comb begin
    busy_d = busy_q;
    cur_d  = cur_q;
    wcnt_d = wcnt_q;
    if (busy_q && !last) begin
      wcnt_d = wcnt_q + 1'b1;
    end else begin
      busy_d = take;
      wcnt_d = '0;
      if (take) cur_d = pick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      cur_q     <= '0;
      wcnt_q    <= '0;
      phy_enb_n <= 1'b1;
      phy_soc   <= 1'b0;
    end else begin
      busy_q    <= busy_d;
      cur_q     <= cur_d;
      wcnt_q    <= wcnt_d;
      phy_enb_n <= !busy_q;
      phy_soc   <= busy_q && (wcnt_q == '0);
    end
  end

  // data path loads only while a word is being pulled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_data <= '0;
      phy_par  <= 1'b1;
    end else if (busy_q) begin
      phy_data <= word;
      phy_par  <= ~^word;
    end
  end

  for (genvar k = 0; k < NPORTS; k++) begin : g_rd
    assign src_rd[k] = busy_q && (cur_q == IDXW'(k));
  end

  AST_SOC_IN_CELL: assert property (@(posedge clk) disable iff (!rst_n)
    phy_soc |-> !phy_enb_n); // R6
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_rd)); // R6
  AST_STROBE_THEN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_rd) |=> !phy_enb_n); // R6
  AST_ODD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    !phy_enb_n |-> ($countones({phy_data, phy_par}) % 2 == 1)); // R8
  if (WORDS > 1) begin : g_soc_gap
    AST_SOC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      phy_soc |=> !phy_soc); // R9
  end
endmodule

// File: rtl/cellbus_tx_master.sv
module cellbus_tx_master
  import cbtx_pkg::*;
#(
  parameter int NPORTS      = 4,
  parameter int DW          = 32,
  parameter int CELL_OCTETS = 52,
  parameter bit DIRECT      = 1'b0,
  parameter bit USE_MAP     = 1'b0,
  parameter logic [MAX_PORTS*ADDR_W-1:0] ADDR_MAP = '0
) (
  input  logic                             clk,
  input  logic                             rst_n,
  output logic [ADDR_W-1:0]                phy_addr,
  output logic                             phy_enb_n,
  input  logic [(DIRECT ? NPORTS : 1)-1:0] phy_clav,
  output logic [DW-1:0]                    phy_data,
  output logic                             phy_soc,
  output logic                             phy_par,
  input  logic [NPORTS-1:0]                src_ready,
  input  logic [NPORTS*DW-1:0]             src_data,
  output logic [NPORTS-1:0]                src_rd
);
  localparam int IDXW  = $clog2(NPORTS);
  localparam int WORDS = CELL_OCTETS / (DW / 8);

  logic [NPORTS-1:0] stat, elig;
  logic              any, take;
  logic [IDXW-1:0]   pick;

  cbtx_scanner #(
    .NPORTS(NPORTS), .DIRECT(DIRECT), .USE_MAP(USE_MAP), .ADDR_MAP(ADDR_MAP)
  ) u_scan (
    .clk(clk), .rst_n(rst_n), .clav(phy_clav),
    .clr_valid(take), .clr_idx(pick),
    .phy_addr(phy_addr), .stat(stat)
  );

  assign elig = stat & src_ready;

  cbtx_rr_arb #(.NPORTS(NPORTS)) u_arb (
    .clk(clk), .rst_n(rst_n), .elig(elig), .take(take),
    .any(any), .pick(pick)
  );

  cbtx_sender #(.NPORTS(NPORTS), .DW(DW), .WORDS(WORDS)) u_send (
    .clk(clk), .rst_n(rst_n), .any(any), .pick(pick), .src_data(src_data),
    .take(take), .src_rd(src_rd), .phy_enb_n(phy_enb_n), .phy_soc(phy_soc),
    .phy_data(phy_data), .phy_par(phy_par)
  );
endmodule

// File: tb/sim_cellbus_tx_master.sv
module sim_harness #(
  parameter int ID = 0,
  parameter int NP = 5,
  parameter int DW = 16,
  parameter int CO = 54,
  parameter bit DIRECT = 1'b0,
  parameter bit USE_MAP = 1'b0,
  parameter logic [154:0] MAP = '0
) (
  input  logic clk,
  input  logic rst_n,
  output logic done,
  output int   checks,
  output int   fails
);
  localparam int W  = CO / (DW / 8);
  localparam int CV = DIRECT ? NP : 1;

  logic [4:0]      phy_addr;
  logic            enb_n, soc, par;
  logic [DW-1:0]   pdata;
  logic [CV-1:0]   clav;
  logic [NP-1:0]   sready, srd;
  logic [NP*DW-1:0] sdata;

  cellbus_tx_master #(
    .NPORTS(NP), .DW(DW), .CELL_OCTETS(CO), .DIRECT(DIRECT),
    .USE_MAP(USE_MAP), .ADDR_MAP(MAP)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .phy_addr(phy_addr), .phy_enb_n(enb_n),
    .phy_clav(clav), .phy_data(pdata), .phy_soc(soc), .phy_par(par),
    .src_ready(sready), .src_data(sdata), .src_rd(srd)
  );

  // source and PHY state
  int avail[NP], wpos[NP], tot[NP], delivered[NP], initc[NP];
  logic [NP-1:0] willing, rd_prev;
  logic [4:0] addr_prev;
  // reference model state
  int m_scan, m_prev, m_rr, m_cur, m_wcnt;
  bit m_prev_v, m_busy;
  logic [NP-1:0] m_stat;
  logic exp_enb_n, exp_soc, exp_par;
  logic [DW-1:0] exp_data;
  // observation
  int cyc, soc_seen, b2b, in_cell, total;
  logic prev_enb_n;

  function automatic logic [4:0] addr_of(int k);
    if (USE_MAP) return MAP[5*k +: 5];
    return 5'(k);
  endfunction

  function automatic int port_of(logic [4:0] a);
    for (int k = 0; k < NP; k++) if (addr_of(k) == a) return k;
    return 0;
  endfunction

  function automatic logic [DW-1:0] word_val(int k, int n);
    logic [31:0] v;
    v = 32'(k * 4099 + n * 97 + 13);
    return v[DW-1:0];
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL h%0d %s: actual %0h expected %0h", ID, tag, act, exp);
    end
  endtask

  initial begin
    done = 1'b0; checks = 0; fails = 0;
    clav = '0; sready = '0; sdata = '0;
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(enb_n === 1'b1 && soc === 1'b0 && srd === '0, "R1 reset outputs",
          {enb_n, soc, 30'(srd)}, 32'h8000_0000);
      chk(phy_addr === addr_of(0), "R1 reset address", phy_addr, addr_of(0));
      total = 0;
      for (int k = 0; k < NP; k++) begin
        initc[k] = 3 + (k % 3); avail[k] = initc[k]; total += initc[k];
        wpos[k] = 0; tot[k] = 0; delivered[k] = 0;
      end
      m_scan = 0; m_prev = 0; m_prev_v = 0; m_rr = 0; m_cur = 0; m_wcnt = 0;
      m_busy = 0; m_stat = '0;
      exp_enb_n = 1'b1; exp_soc = 1'b0; exp_data = '0; exp_par = 1'b1;
      rd_prev = '0; addr_prev = addr_of(0);
      cyc = 0; soc_seen = 0; b2b = 0; in_cell = 0; prev_enb_n = 1'b1;
    end else if (!done) begin
      logic [NP-1:0] exp_rd, elig;
      bit any, last, take;
      int pick, dsum;
      cyc++;
      // compare outputs against the model
      chk(phy_addr == addr_of(m_scan), "R2 address scan", phy_addr, addr_of(m_scan));
      chk(enb_n == exp_enb_n, "R6 enable", enb_n, exp_enb_n);
      chk(soc == exp_soc, "R6 start of cell", soc, exp_soc);
      for (int k = 0; k < NP; k++) exp_rd[k] = m_busy && (m_cur == k);
      chk(srd == exp_rd, "R5 R3 R4 R10 selection strobe", 32'(srd), 32'(exp_rd));
      if (!enb_n) begin
        chk(pdata == exp_data, "R6 cell word", 32'(pdata), 32'(exp_data));
        chk(par == exp_par, "R8 odd parity", par, exp_par);
      end
      // cell framing as seen on the bus
      if (!enb_n) begin
        if (soc) begin
          soc_seen++;
          if (in_cell != 0) begin
            b2b++;
            chk(in_cell == W, "R9 words per cell", in_cell, W);
          end
          in_cell = 1;
        end else in_cell++;
      end else if (!prev_enb_n) begin
        chk(in_cell == W, "R9 words per cell", in_cell, W);
        in_cell = 0;
      end
      prev_enb_n = enb_n;
      // sources consume the words taken at the last edge
      for (int k = 0; k < NP; k++) if (rd_prev[k]) begin
        if (wpos[k] == 0) avail[k]--;
        tot[k]++; wpos[k]++;
        if (wpos[k] == W) begin wpos[k] = 0; delivered[k]++; end
      end
      // PHY willingness phases
      for (int k = 0; k < NP; k++) begin
        if (cyc < 150)      willing[k] = 1'b1;
        else if (cyc < 400) willing[k] = (k % 2 == 0);
        else if (cyc < 700) willing[k] = (((cyc / 7) + k) % 3 != 0);
        else                willing[k] = 1'b1;
      end
      // drive inputs for the coming edge
      for (int k = 0; k < NP; k++) begin
        sready[k] = avail[k] > 0;
        sdata[DW*k +: DW] = word_val(k, tot[k]);
      end
      if (DIRECT) clav = CV'(willing);
      else        clav = CV'(willing[port_of(addr_prev)]);
      // reference model step
      elig = m_stat & sready;
      any = 0; pick = 0;
      for (int off = 0; off < NP; off++) begin
        int c;
        c = (m_rr + off) % NP;
        if (!any && elig[c]) begin any = 1; pick = c; end
      end
      last = m_busy && (m_wcnt == W - 1);
      take = (!m_busy || last) && any;
      if (m_busy) begin
        exp_enb_n = 1'b0; exp_soc = (m_wcnt == 0);
        exp_data = word_val(m_cur, tot[m_cur]);
        exp_par = ($countones(exp_data) % 2 == 0);
      end else begin
        exp_enb_n = 1'b1; exp_soc = 1'b0;
      end
      if (DIRECT) m_stat = willing;
      else if (m_prev_v) m_stat[m_prev] = willing[port_of(addr_prev)];
      if (take) m_stat[pick] = 1'b0;
      if (m_busy && !last) m_wcnt++;
      else begin
        m_busy = take; m_wcnt = 0;
        if (take) begin m_cur = pick; m_rr = (pick + 1) % NP; end
      end
      m_prev = m_scan; m_prev_v = 1; m_scan = (m_scan + 1) % NP;
      rd_prev = srd; addr_prev = phy_addr;
      // completion
      dsum = 0;
      for (int k = 0; k < NP; k++) dsum += delivered[k];
      if ((cyc >= 700 && dsum == total && enb_n) || cyc > 20000) begin
        for (int k = 0; k < NP; k++)
          chk(delivered[k] == initc[k],
              DIRECT ? "R4 R5 direct-status port drained" : "R3 R5 polled port drained",
              delivered[k], initc[k]);
        chk(soc_seen == total, "R6 cells framed", soc_seen, total);
        chk(b2b > 0, "R7 back-to-back cells seen", b2b, 1);
        done = 1'b1;
      end
    end
  end
endmodule

module sim_cellbus_tx_master;
  logic clk, rst_n;
  logic d0, d1, d2;
  int   c0, c1, c2, f0, f1, f2;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // polled status, address map, 16-bit bus, 54-octet cells
  sim_harness #(.ID(0), .NP(5), .DW(16), .CO(54), .DIRECT(1'b0), .USE_MAP(1'b1),
    .MAP({130'd0, 5'd22, 5'd9, 5'd30, 5'd17, 5'd3}))
    h_poll (.clk(clk), .rst_n(rst_n), .done(d0), .checks(c0), .fails(f0));
  // direct status, 32-bit bus, 52-octet cells
  sim_harness #(.ID(1), .NP(4), .DW(32), .CO(52), .DIRECT(1'b1), .USE_MAP(1'b0))
    h_direct (.clk(clk), .rst_n(rst_n), .done(d1), .checks(c1), .fails(f1));
  // polled status, direct addresses, 8-bit bus, 53-octet cells
  sim_harness #(.ID(2), .NP(3), .DW(8), .CO(53), .DIRECT(1'b0), .USE_MAP(1'b0))
    h_byte (.clk(clk), .rst_n(rst_n), .done(d2), .checks(c2), .fails(f2));

  initial begin
    int checks, fails;
    bit finished;
    rst_n = 1'b0;
    #47 rst_n = 1'b1;
    finished = 1'b0;
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (d0 && d1 && d2) begin finished = 1'b1; break; end
    end
    #1;
    checks = c0 + c1 + c2 + 1;
    fails  = f0 + f1 + f2;
    if (!finished) begin
      fails++;
      $display("FAIL R5 watchdog: actual unfinished expected finished");
    end
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule